// File: doc/BRIEF.md
# Mini UART register front end

This block is the register side of a simplified auxiliary serial port. A host reaches it through a 32-bit register port, selected by byte offset, with separate read and write strobes. Received characters arrive on a byte stream guarded by a valid/ready handshake and collect in a circular receive queue. Every byte the host writes to the data register leaves at once on a transmit byte stream as a one-cycle pulse. The transmit side never holds data, so it always reports itself idle and empty.

The block keeps two interrupt-enable bits and drives one level interrupt. It builds the status and identification words from the queue fill level and the pending cause. The remaining registers either return fixed values or read as zero. A read returns its word one cycle after the strobe. A read of the data register removes the head byte from the queue.

Top module: `muart_regif`

## Requirements
- R1: After reset, irq, tx_valid and bus_rvalid are 0 and rx_ready is 1. A read strobe in one cycle raises bus_rvalid in the next cycle, with bus_rdata holding the word sampled at the strobe.
- R2: A write to offset 0x44 keeps only data bits 1:0 (bit 0 = receive enable, bit 1 = transmit enable). A read of 0x44 returns those bits ORed with 0xC0.
- R3: irq is 1 exactly when the transmit enable is set, or when the receive enable is set and the queue holds at least one byte.
- R4: A read of 0x48 returns 0xC0 plus 0x4 if the queue holds data (otherwise 0x2), plus 0x1 if irq is 0.
- R5: A write to 0x48 with data bit 1 set empties the queue and leaves the head position unchanged. A write to 0x48 with bit 1 clear changes nothing.
- R6: A read of 0x40 returns the oldest queued byte in arrival order and removes it. Positions wrap at the depth (default 8).
- R7: A read of 0x40 while the queue is empty returns the byte last stored at the head position and does not move the head.
- R8: A read of 0x54 returns 0x60, with bit 0 set when the queue is not empty.
- R9: A read of 0x64 returns 0x30E, with bit 0 set when the queue is not empty and the fill count placed at bit 16 upward.
- R10: Offset 0x04 reads 1 and offset 0x60 reads 3. Offset 0x00 reads the current irq level as bit 0.
- R11: rx_ready is 0 while the queue holds depth bytes. A byte offered while rx_ready is 0 is not stored.
- R12: Offsets 0x4C, 0x50, 0x58, 0x5C, 0x68 and any other offset not listed in R2 to R10 read as 0. Writes to them change no state.
- R13: A write to 0x40 puts data bits 7:0 on tx_byte, with tx_valid high for the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (8) | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| rx_byte | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Queue can accept a byte |
| tx_byte | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte pulse |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a data read on an empty queue whose head position has wrapped. Reaching it needs the queue filled to the limit, partly drained, refilled across the wrap point and then drained completely. The stimulus follows that sequence and also offers one byte while the queue is full. After the empty reads it pushes a single byte and reads it back, which shows that the head did not move. A flush with bytes still queued is then followed by an empty read, which shows that the head survives the flush.

// File: rtl/muart_pkg.sv
package muart_pkg;
  localparam logic [7:0] OFS_IRQSUM = 8'h00;
  localparam logic [7:0] OFS_ENABLE = 8'h04;
  localparam logic [7:0] OFS_DATA   = 8'h40;
  localparam logic [7:0] OFS_IEN    = 8'h44;
  localparam logic [7:0] OFS_IID    = 8'h48;
  localparam logic [7:0] OFS_LSTAT  = 8'h54;
  localparam logic [7:0] OFS_CTRL   = 8'h60;
  localparam logic [7:0] OFS_XSTAT  = 8'h64;

  localparam logic [31:0] FIFO_FLAGS  = 32'h0000_00C0;
  localparam logic [31:0] LSTAT_BASE  = 32'h0000_0060;
  localparam logic [31:0] XSTAT_BASE  = 32'h0000_030E;
  localparam logic [31:0] ENABLE_WORD = 32'h0000_0001;
  localparam logic [31:0] CTRL_WORD   = 32'h0000_0003;
  localparam int          XSTAT_FILL_LSB = 16;

  typedef struct packed {
    logic tx_en;
    logic rx_en;
  } ien_t;
endpackage

// File: rtl/muart_rx_fifo.sv
module muart_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  output logic          push_ready,
  input  logic          pop_req,
  input  logic          flush,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] fill
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] wr_slot;
  logic [CW:0]   slot_sum;
  logic          push_fire;
  logic          pop_fire;

  assign push_ready = (fill != CW'(DEPTH));
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop_req && (fill != '0);
  assign head_data  = mem[rd_ptr];

  always_comb begin
    slot_sum = {{(CW + 1 - PW){1'b0}}, rd_ptr} + {1'b0, fill};
    if (slot_sum >= (CW + 1)'(DEPTH)) slot_sum = slot_sum - (CW + 1)'(DEPTH);
    wr_slot = slot_sum[PW-1:0];
  end

  // storage without reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_slot] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
    end else if (pop_fire) begin
      rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     fill <= '0;
    else if (flush)              fill <= '0;
    else if (push_fire && !pop_fire) fill <= fill + 1'b1;
    else if (!push_fire && pop_fire) fill <= fill - 1'b1;
  end

  a_r11_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));
  a_r11_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (fill == CW'(DEPTH) && !pop_req && !flush) |=> fill == CW'(DEPTH));
  a_r7_empty_pop_holds: assert property (@(posedge clk) disable iff (rst)
    (pop_req && fill == '0) |=> $stable(rd_ptr));
  a_r5_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> fill == '0);
endmodule

// File: rtl/muart_irq_ctl.sv
module muart_irq_ctl
  import muart_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ien_wr,
  input  logic [1:0] ien_wdata,
  input  logic       rx_nonempty,
  output ien_t       ien,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (rst)         ien <= '0;
    else if (ien_wr) ien <= ien_t'(ien_wdata);
  end

  assign irq = ien.tx_en || (ien.rx_en && rx_nonempty);

  a_r3_tx_forces_irq: assert property (@(posedge clk) disable iff (rst)
    ien.tx_en |-> irq);
  a_r3_no_enable_no_irq: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |-> !irq);
  a_r2_ien_write: assert property (@(posedge clk) disable iff (rst)
    ien_wr |=> ien == ien_t'($past(ien_wdata)));
endmodule

// File: rtl/muart_regif.sv
module muart_regif
  import muart_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_rd,
  output logic [31:0]   bus_rdata,
  output logic          bus_rvalid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic [7:0]    tx_byte,
  output logic          tx_valid,
  output logic          irq
);
  logic          wr_data, wr_ien, wr_flush, rd_pop;
  logic [7:0]    head_data;
  logic [CW-1:0] fill;
  logic          nonempty;
  ien_t          ien;
  logic [31:0]   rd_word;

  assign wr_data  = bus_wr && (bus_addr == AW'(OFS_DATA));
  assign wr_ien   = bus_wr && (bus_addr == AW'(OFS_IEN));
  assign wr_flush = bus_wr && (bus_addr == AW'(OFS_IID)) && bus_wdata[1];
  assign rd_pop   = bus_rd && (bus_addr == AW'(OFS_DATA));
  assign nonempty = (fill != '0);

  muart_rx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push_valid(rx_valid),
    .push_data (rx_byte),
    .push_ready(rx_ready),
    .pop_req   (rd_pop),
    .flush     (wr_flush),
    .head_data (head_data),
    .fill      (fill)
  );

  muart_irq_ctl u_irq (
    .clk        (clk),
    .rst        (rst),
    .ien_wr     (wr_ien),
    .ien_wdata  (bus_wdata[1:0]),
    .rx_nonempty(nonempty),
    .ien        (ien),
    .irq        (irq)
  );

  always_comb begin
    rd_word = '0;
    case (bus_addr)
      AW'(OFS_IRQSUM): rd_word = {31'b0, irq};
      AW'(OFS_ENABLE): rd_word = ENABLE_WORD;
      AW'(OFS_DATA):   rd_word = {24'b0, head_data};
      AW'(OFS_IEN):    rd_word = FIFO_FLAGS | {30'b0, ien};
      AW'(OFS_IID):    rd_word = FIFO_FLAGS | (nonempty ? 32'h4 : 32'h2)
                                 | {31'b0, !irq};
      AW'(OFS_LSTAT):  rd_word = LSTAT_BASE | {31'b0, nonempty};
      AW'(OFS_CTRL):   rd_word = CTRL_WORD;
      AW'(OFS_XSTAT):  rd_word = XSTAT_BASE | {31'b0, nonempty}
                                 | (32'(fill) << XSTAT_FILL_LSB);
      default:         rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_byte  <= '0;
      tx_valid <= 1'b0;
    end else begin
      tx_valid <= wr_data;
      if (wr_data) tx_byte <= bus_wdata[7:0];
    end
  end

  a_r1_rvalid_follows_rd: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_rd));
  a_r13_tx_from_write: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(bus_wr && bus_addr == AW'(OFS_DATA)));
  a_r13_tx_payload: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> tx_byte == $past(bus_wdata[7:0]));
endmodule

// File: tb/muart_regif_tb.sv
module muart_regif_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  muart_regif #(.DEPTH(DEPTH), .AW(8)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_byte(tx_byte), .tx_valid(tx_valid), .irq(irq)
  );

  int n_checks = 0;
  int n_errs = 0;
  bit done = 1'b0;

  // reference model built from the requirements
  logic [7:0] m_mem [DEPTH];
  int m_ptr = 0;
  int m_cnt = 0;
  logic [1:0] m_ien = 2'b00;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic m_irq();
    return m_ien[1] || (m_ien[0] && m_cnt != 0);
  endfunction

  function automatic logic [31:0] expect_word(logic [7:0] a);
    logic [31:0] w;
    case (a)
      8'h00: w = {31'b0, m_irq()};
      8'h04: w = 32'h1;
      8'h40: w = {24'b0, m_mem[m_ptr]};
      8'h44: w = 32'hC0 | {30'b0, m_ien};
      8'h48: w = 32'hC0 | ((m_cnt != 0) ? 32'h4 : 32'h2) | {31'b0, !m_irq()};
      8'h54: w = 32'h60 | {31'b0, m_cnt != 0};
      8'h60: w = 32'h3;
      8'h64: w = 32'h30E | {31'b0, m_cnt != 0} | (32'(m_cnt) << 16);
      default: w = 32'h0;
    endcase
    return w;
  endfunction

  // monitor: compares read responses against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_errs++;
        $display("FAIL R1: actual=rvalid expected=no response");
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus_read(logic [7:0] a, string tag);
    exp_q.push_back(expect_word(a));
    tag_q.push_back(tag);
    if (a == 8'h40 && m_cnt > 0) begin
      m_cnt--;
      m_ptr = (m_ptr + 1) % DEPTH;
    end
    bus_addr = a;
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    if (a == 8'h44) m_ien = d[1:0];
    if (a == 8'h48 && d[1]) m_cnt = 0;
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic push_rx(logic [7:0] b);
    check("R11 rx_ready", {31'b0, rx_ready}, {31'b0, m_cnt < DEPTH});
    if (m_cnt < DEPTH) begin
      m_mem[(m_ptr + m_cnt) % DEPTH] = b;
      m_cnt++;
    end
    rx_byte = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    check("R1 rvalid", {31'b0, bus_rvalid}, 32'h0);
    check("R1 rx_ready", {31'b0, rx_ready}, 32'h1);

    // R10 constants and summary
    bus_read(8'h04, "R10 enables");
    bus_read(8'h60, "R10 control");
    bus_read(8'h00, "R10 summary idle");

    // R2 enable masking, R3 interrupt
    bus_write(8'h44, 32'hFFFF_FFFF);
    bus_read(8'h44, "R2 ien masked");
    check("R3 irq tx enabled", {31'b0, irq}, 32'h1);
    bus_read(8'h00, "R10 summary tx");
    bus_read(8'h48, "R4 iid tx pending");
    bus_write(8'h44, 32'h0);
    check("R3 irq off", {31'b0, irq}, 32'h0);
    bus_write(8'h44, 32'h1);
    check("R3 irq rx empty", {31'b0, irq}, 32'h0);
    bus_read(8'h48, "R4 iid none");

    // R11 fill to the limit, R9 full count
    for (int i = 0; i < DEPTH; i++) push_rx(8'hA0 + 8'(i));
    check("R11 ready low when full", {31'b0, rx_ready}, 32'h0);
    check("R3 irq rx data", {31'b0, irq}, 32'h1);
    push_rx(8'hEE);
    bus_read(8'h64, "R9 xstat full");
    bus_read(8'h54, "R8 lstat data");
    bus_read(8'h48, "R4 iid rx pending");
    for (int i = 0; i < 3; i++) bus_read(8'h40, "R6 pop order");
    for (int i = 0; i < 3; i++) push_rx(8'hB0 + 8'(i));
    bus_read(8'h64, "R9 xstat after wrap");
    for (int i = 0; i < DEPTH; i++) bus_read(8'h40, "R6 pop across wrap");
    bus_read(8'h54, "R8 lstat empty");
    bus_read(8'h64, "R9 xstat empty");
    check("R3 irq drained", {31'b0, irq}, 32'h0);

    // R7 empty reads hold the head
    bus_read(8'h40, "R7 empty read stale");
    bus_read(8'h40, "R7 empty read again");
    push_rx(8'hC5);
    bus_read(8'h40, "R7 head unmoved");

    // R5 flush
    push_rx(8'h11);
    push_rx(8'h22);
    bus_write(8'h48, 32'h1);
    bus_read(8'h64, "R5 no flush without bit1");
    bus_write(8'h48, 32'h2);
    bus_read(8'h64, "R5 flushed count");
    check("R5 ready after flush", {31'b0, rx_ready}, 32'h1);
    bus_read(8'h40, "R5 head kept after flush");

    // R13 transmit pulse
    bus_write(8'h40, 32'h0000_015A);
    check("R13 tx_valid", {31'b0, tx_valid}, 32'h1);
    check("R13 tx_byte", {24'b0, tx_byte}, 32'h5A);
    @(negedge clk);
    check("R13 tx_valid single", {31'b0, tx_valid}, 32'h0);
    bus_read(8'h64, "R13 tx write no pop");

    // R12 unimplemented offsets
    bus_write(8'h4C, 32'hFF);
    bus_write(8'h5C, 32'hFF);
    bus_write(8'h68, 32'hFF);
    bus_write(8'h80, 32'hFF);
    bus_read(8'h4C, "R12 lcr zero");
    bus_read(8'h50, "R12 mcr zero");
    bus_read(8'h58, "R12 msr zero");
    bus_read(8'h5C, "R12 scratch zero");
    bus_read(8'h68, "R12 baud zero");
    bus_read(8'h80, "R12 undefined zero");
    bus_read(8'h44, "R12 ien untouched");
    bus_read(8'h64, "R12 fifo untouched");

    repeat (2) @(negedge clk);
    check("R1 all responses seen", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule